// File: doc/BRIEF.md
# DDR SDRAM command decoder and bank tracker

This block sits behind the command pins of a double-data-rate SDRAM and turns the strobe levels sampled on each rising clock edge into decoded commands. Chip select, row strobe, column strobe and write enable pick the command. Clock enable tells auto-refresh apart from self-refresh entry. Address bit 10 selects auto-precharge on a read or write, and precharge-all on a precharge.

For each of four banks the block keeps a state and the open row. The state is idle, open, or closing (an auto-precharge burst is still running). Every legal command leaves a one-cycle strobe, carrying the bank, row and column it was issued with. An illegal command leaves only an error pulse and does not touch the bank state. The burst length used to time auto-precharge closure comes from a two-bit select input.

All outputs are registered. A command sampled on clock edge k shows its strobe, fields and bank-state effect on the outputs from edge k onward, and they can be read before edge k+1.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With cs_ni high the cycle is a no-operation. No strobe or error is raised, and the bank state and command fields are unchanged.
- R2: With cs_ni low, the command is selected by {ras_ni,cas_ni,we_ni}: 011 is activate, 101 is read, 100 is write, 010 is precharge. A legal command raises act_o, rd_o, wr_o or pre_o for one cycle. On act_o, rd_o, wr_o and pre_o, cmd_bank_o = ba_i, cmd_row_o = addr_i[11:0] and cmd_col_o = addr_i[9:0]. These fields hold until the next such command.
- R3: An activate to an idle bank makes that bank open. Its bank_active_o bit (bit = bank number) goes high, and its open_row_o field (bits bank*12 +: 12) takes the row.
- R4: A legal read or write with addr_i[10] low leaves the bank open. With addr_i[10] high it sets ap_o, and the bank returns to idle (row field zero) after BL/2 clock edges following the command edge. BL is given by bl_sel_i: 00 is 2, 01 is 4, 10 and 11 are 8.
- R5: A precharge with addr_i[10] low idles only bank ba_i. With addr_i[10] high it idles all banks and sets pre_all_o. A bank that goes idle has its row field cleared to zero. A precharge is never illegal, and it also cuts short a closing bank.
- R6: Encoding 001 with cke_i high and all banks idle raises ref_o, and all banks stay idle.
- R7: Encoding 001 with cke_i low and all banks idle raises sref_o and sets self_ref_o. While self_ref_o is high, every command is ignored. self_ref_o clears after the first edge at which cke_i is sampled high, and the command on that edge is also ignored.
- R8: These commands are illegal: an activate to a bank that is not idle, a read or write to a bank that is not open (idle or closing), and a refresh of either kind while any bank is not idle. An illegal command raises err_o for one cycle, raises no strobe, and leaves the bank state and command fields unchanged.
- R9: While rst_ni is low, all banks are idle, every row field is zero, and all strobes, fields and self_ref_o are zero.
- R10: Encodings 111, 110 and 000 are no-operations. cke_i has no effect except on encoding 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable (refresh kind, self-refresh exit) |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Row / column address, bit 10 = precharge option |
| bl_sel_i | input | 2 | Burst length select |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Auto-refresh strobe |
| sref_o | output | 1 | Self-refresh entry strobe |
| ap_o | output | 1 | Auto-precharge with read/write strobe |
| pre_all_o | output | 1 | Precharge-all with precharge strobe |
| err_o | output | 1 | Illegal command pulse |
| cmd_bank_o | output | 2 | Bank of last legal command |
| cmd_row_o | output | 12 | Row address of last legal command |
| cmd_col_o | output | 10 | Column address of last legal command |
| bank_active_o | output | 4 | Per-bank not-idle flags |
| open_row_o | output | 48 | Per-bank open row, 12 bits each |
| self_ref_o | output | 1 | In self-refresh |

## Verification
The bench builds the block with its default parameters: 12-bit rows, 10-bit columns, a 2-bit bank address giving four banks, and a maximum burst of 8. Random bank addresses therefore reach every bank slot. All four burst selects are reachable, so the closing countdown runs for 1, 2 and 4 clocks. Precharges and reads or writes often arrive while a bank is still closing. Directed sequences cover the cases random traffic rarely hits: refresh with all banks idle, a stay in self-refresh, and a precharge that cuts an auto-precharge short.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_SREF
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_CLOSING
  } bank_st_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = cke_i ? CMD_REF : CMD_SREF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    if (cs_ni) begin
      AST_CS_HIGH_NOP: assert (cmd_o == CMD_NOP); // R1
    end
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             do_act_i,
  input  logic             do_ap_i,
  input  logic             do_close_i,
  input  logic [CNT_W-1:0] ap_clks_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             idle_o,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);
  bank_st_e         state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (do_close_i) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (do_act_i) begin
      state_q <= BK_OPEN;
      row_q   <= row_i;
    end else if (do_ap_i) begin
      state_q <= BK_CLOSING;
      cnt_q   <= ap_clks_i;
    end else if (state_q == BK_CLOSING) begin
      if (cnt_q == '0) begin
        state_q <= BK_IDLE;
        row_q   <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign idle_o = (state_q == BK_IDLE);
  assign open_o = (state_q == BK_OPEN);
  assign row_o  = row_q;

  AST_ACT_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_act_i |-> state_q == BK_IDLE); // R8
  AST_AP_FROM_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ap_i |-> state_q == BK_OPEN); // R8
  AST_CLOSE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_close_i |=> (state_q == BK_IDLE && row_q == '0)); // R5
  AST_AP_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_CLOSING && cnt_q == '0 && !do_close_i) |=> state_q == BK_IDLE); // R4
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int MAX_BURST = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_ni,
  input  logic                          ras_ni,
  input  logic                          cas_ni,
  input  logic                          we_ni,
  input  logic                          cke_i,
  input  logic [BANK_W-1:0]             ba_i,
  input  logic [ROW_W-1:0]              addr_i,
  input  logic [1:0]                    bl_sel_i,
  output logic                          act_o,
  output logic                          rd_o,
  output logic                          wr_o,
  output logic                          pre_o,
  output logic                          ref_o,
  output logic                          sref_o,
  output logic                          ap_o,
  output logic                          pre_all_o,
  output logic                          err_o,
  output logic [BANK_W-1:0]             cmd_bank_o,
  output logic [ROW_W-1:0]              cmd_row_o,
  output logic [COL_W-1:0]              cmd_col_o,
  output logic [(1<<BANK_W)-1:0]        bank_active_o,
  output logic [(1<<BANK_W)*ROW_W-1:0]  open_row_o,
  output logic                          self_ref_o
);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int CNT_W     = (MAX_BURST > 4) ? $clog2(MAX_BURST / 2) : 1;

  cmd_e                 cmd_raw, cmd;
  logic                 self_ref_q;
  logic [NUM_BANKS-1:0] bank_idle, bank_open;
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];
  logic [CNT_W-1:0]     ap_clks;
  logic                 ap_bit, all_idle;
  logic                 act_ok, rd_ok, wr_ok, pre_ok, ref_ok, sref_ok, illegal;

  ddr_cmd_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cke_i (cke_i),
    .cmd_o (cmd_raw)
  );

  // self-refresh masks every command
  assign cmd      = self_ref_q ? CMD_NOP : cmd_raw;
  assign ap_bit   = addr_i[AP_BIT];
  assign all_idle = &bank_idle;

  // countdown in clocks minus one: BL2 -> 0, BL4 -> 1, BL8 -> 3
  always_comb begin
    case (bl_sel_i)
      2'b00:   ap_clks = CNT_W'(0);
      2'b01:   ap_clks = CNT_W'(1);
      default: ap_clks = CNT_W'(MAX_BURST / 2 - 1);
    endcase
  end

  always_comb begin
    act_ok  = (cmd == CMD_ACT)  &&  bank_idle[ba_i];
    rd_ok   = (cmd == CMD_RD)   &&  bank_open[ba_i];
    wr_ok   = (cmd == CMD_WR)   &&  bank_open[ba_i];
    pre_ok  = (cmd == CMD_PRE);
    ref_ok  = (cmd == CMD_REF)  &&  all_idle;
    sref_ok = (cmd == CMD_SREF) &&  all_idle;
    illegal = ((cmd == CMD_ACT) && !bank_idle[ba_i]) ||
              ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba_i]) ||
              ((cmd == CMD_REF || cmd == CMD_SREF) && !all_idle);
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (ba_i == BANK_W'(b));
      ddr_bank_slot #(
        .ROW_W(ROW_W),
        .CNT_W(CNT_W)
      ) u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .do_act_i  (act_ok && hit),
        .do_ap_i   ((rd_ok || wr_ok) && ap_bit && hit),
        .do_close_i(pre_ok && (ap_bit || hit)),
        .ap_clks_i (ap_clks),
        .row_i     (addr_i),
        .idle_o    (bank_idle[b]),
        .open_o    (bank_open[b]),
        .row_o     (bank_row[b])
      );
      assign open_row_o[b*ROW_W +: ROW_W] = bank_row[b];
    end
  endgenerate

  assign bank_active_o = ~bank_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o      <= 1'b0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      pre_o      <= 1'b0;
      ref_o      <= 1'b0;
      sref_o     <= 1'b0;
      ap_o       <= 1'b0;
      pre_all_o  <= 1'b0;
      err_o      <= 1'b0;
      cmd_bank_o <= '0;
      cmd_row_o  <= '0;
      cmd_col_o  <= '0;
      self_ref_q <= 1'b0;
    end else begin
      act_o     <= act_ok;
      rd_o      <= rd_ok;
      wr_o      <= wr_ok;
      pre_o     <= pre_ok;
      ref_o     <= ref_ok;
      sref_o    <= sref_ok;
      ap_o      <= (rd_ok || wr_ok) && ap_bit;
      pre_all_o <= pre_ok && ap_bit;
      err_o     <= illegal;
      if (act_ok || rd_ok || wr_ok || pre_ok) begin
        cmd_bank_o <= ba_i;
        cmd_row_o  <= addr_i;
        cmd_col_o  <= addr_i[COL_W-1:0];
      end
      if (self_ref_q) begin
        if (cke_i) self_ref_q <= 1'b0;
      end else if (sref_ok) begin
        self_ref_q <= 1'b1;
      end
    end
  end

  assign self_ref_o = self_ref_q;

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, sref_o, err_o})); // R2
  AST_CS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !(act_o || rd_o || wr_o || pre_o || ref_o || sref_o || err_o)); // R1
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> bank_active_o[cmd_bank_o]); // R3
  AST_REF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> bank_active_o == '0); // R6
  AST_SREF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o |-> bank_active_o == '0); // R7
  AST_SREF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && !cke_i) |=> self_ref_o); // R7
  AST_SREF_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o |=> !(act_o || rd_o || wr_o || pre_o || ref_o || sref_o || err_o)); // R7
  AST_ERR_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(cmd_row_o) && $stable(cmd_bank_o)); // R8
endmodule

// File: tb/sim_ddr_cmd_tracker.sv
module sim_ddr_cmd_tracker;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b1;
  logic [1:0]  ba_i = '0, bl_sel_i = '0;
  logic [11:0] addr_i = '0;
  logic        act_o, rd_o, wr_o, pre_o, ref_o, sref_o, ap_o, pre_all_o, err_o, self_ref_o;
  logic [1:0]  cmd_bank_o;
  logic [11:0] cmd_row_o;
  logic [9:0]  cmd_col_o;
  logic [3:0]  bank_active_o;
  logic [47:0] open_row_o;

  int total = 0, bad = 0;

  // reference model
  int          m_st [4];
  int          m_cnt[4];
  logic [11:0] m_row[4];
  logic        m_sref = 1'b0;
  logic [1:0]  e_bank = '0;
  logic [11:0] e_row = '0;
  logic [9:0]  e_col = '0;

  always #(PERIOD/2) clk = ~clk;

  ddr_cmd_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .cke_i(cke_i), .ba_i(ba_i), .addr_i(addr_i), .bl_sel_i(bl_sel_i),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
    .sref_o(sref_o), .ap_o(ap_o), .pre_all_o(pre_all_o), .err_o(err_o),
    .cmd_bank_o(cmd_bank_o), .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o),
    .bank_active_o(bank_active_o), .open_row_o(open_row_o), .self_ref_o(self_ref_o)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int ap_len(input logic [1:0] bl);
    return (bl == 2'b00) ? 0 : (bl == 2'b01) ? 1 : 3;
  endfunction

  function automatic logic [3:0] exp_active();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = (m_st[b] != 0);
    return v;
  endfunction

  function automatic logic [47:0] exp_rows();
    logic [47:0] v;
    for (int b = 0; b < 4; b++) v[b*12 +: 12] = m_row[b];
    return v;
  endfunction

  task automatic compare_all(input logic [8:0] ev, input string tag);
    logic [8:0] got;
    got = {act_o, rd_o, wr_o, pre_o, ref_o, sref_o, ap_o, pre_all_o, err_o};
    check(got == ev, tag, "events", 64'(got), 64'(ev));
    check({cmd_bank_o, cmd_row_o, cmd_col_o} == {e_bank, e_row, e_col}, tag, "fields",
          64'({cmd_bank_o, cmd_row_o, cmd_col_o}), 64'({e_bank, e_row, e_col}));
    check(bank_active_o == exp_active(), tag, "bank_active",
          64'(bank_active_o), 64'(exp_active()));
    check(open_row_o == exp_rows(), tag, "open_row", 64'(open_row_o), 64'(exp_rows()));
    check(self_ref_o == m_sref, tag, "self_ref", 64'(self_ref_o), 64'(m_sref));
  endtask

  // drive one command at a negedge, model it, check after the edge
  task automatic step(input logic cs, input logic [2:0] rcw, input logic cke,
                      input logic [1:0] ba, input logic [11:0] addr,
                      input logic [1:0] bl, input string tag);
    logic e_act = 0, e_rd = 0, e_wr = 0, e_pre = 0, e_ref = 0, e_sref = 0;
    logic e_ap = 0, e_pall = 0, e_err = 0, all_idle = 1;
    int   kind = 0; // 1 act, 2 ap, 3 close one, 4 close all
    cs_ni = cs; {ras_ni, cas_ni, we_ni} = rcw; cke_i = cke;
    ba_i = ba; addr_i = addr; bl_sel_i = bl;
    for (int b = 0; b < 4; b++) if (m_st[b] != 0) all_idle = 0;
    if (m_sref) begin
      if (cke) m_sref = 1'b0;
    end else if (!cs) begin
      case (rcw)
        3'b011: if (m_st[ba] == 0) begin e_act = 1; kind = 1; end else e_err = 1;
        3'b101, 3'b100:
          if (m_st[ba] == 1) begin
            e_rd = (rcw == 3'b101); e_wr = (rcw == 3'b100); e_ap = addr[10];
            if (addr[10]) kind = 2;
          end else e_err = 1;
        3'b010: begin e_pre = 1; e_pall = addr[10]; kind = addr[10] ? 4 : 3; end
        3'b001:
          if (!all_idle) e_err = 1;
          else if (cke) e_ref = 1;
          else begin e_sref = 1; m_sref = 1'b1; end
        default: ;
      endcase
    end
    if (e_act || e_rd || e_wr || e_pre) begin e_bank = ba; e_row = addr; e_col = addr[9:0]; end
    for (int b = 0; b < 4; b++)
      if (m_st[b] == 2) begin
        if (m_cnt[b] == 0) begin m_st[b] = 0; m_row[b] = '0; end
        else m_cnt[b]--;
      end
    case (kind)
      1: begin m_st[ba] = 1; m_row[ba] = addr; end
      2: begin m_st[ba] = 2; m_cnt[ba] = ap_len(bl); end
      3: begin m_st[ba] = 0; m_cnt[ba] = 0; m_row[ba] = '0; end
      4: for (int b = 0; b < 4; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_row[b] = '0; end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    compare_all({e_act, e_rd, e_wr, e_pre, e_ref, e_sref, e_ap, e_pall, e_err}, tag);
  endtask

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         RF = 3'b001, NOP = 3'b111;

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_row[b] = '0; end
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    compare_all(9'b0, "R9");
    rst_ni = 1'b1;

    // R1: chip select high masks an activate
    step(1'b1, ACT, 1'b1, 2'd0, 12'h123, 2'b00, "R1");
    // R2/R3: open bank 0 and bank 3
    step(1'b0, ACT, 1'b1, 2'd0, 12'hABC, 2'b00, "R3");
    step(1'b0, ACT, 1'b1, 2'd3, 12'h5A5, 2'b00, "R3");
    // R8: activate to open bank
    step(1'b0, ACT, 1'b1, 2'd0, 12'h001, 2'b00, "R8");
    // R2: read without auto-precharge, write to idle bank is illegal
    step(1'b0, RD, 1'b1, 2'd0, 12'h0F3, 2'b00, "R2");
    step(1'b0, WR, 1'b0, 2'd1, 12'h011, 2'b00, "R8");
    // R10: other encodings and cke on non-refresh
    step(1'b0, 3'b110, 1'b1, 2'd0, 12'hFFF, 2'b00, "R10");
    step(1'b0, 3'b000, 1'b1, 2'd0, 12'hFFF, 2'b00, "R10");
    step(1'b0, NOP, 1'b0, 2'd0, 12'h000, 2'b00, "R10");
    // R8: refresh with banks open
    step(1'b0, RF, 1'b1, 2'd0, 12'h000, 2'b00, "R8");
    // R4: write with auto-precharge, BL8 on bank 0 -> idle after 4 edges
    step(1'b0, WR, 1'b1, 2'd0, 12'h400, 2'b10, "R4");
    step(1'b0, RD, 1'b1, 2'd0, 12'h000, 2'b00, "R8");
    repeat (4) step(1'b0, NOP, 1'b1, 2'd0, 12'h000, 2'b00, "R4");
    // R4: BL2 read on bank 3 -> idle after one edge
    step(1'b0, RD, 1'b1, 2'd3, 12'h7FF, 2'b00, "R4");
    step(1'b0, NOP, 1'b1, 2'd0, 12'h000, 2'b00, "R4");
    // R5: single and all-bank precharge, precharge cutting a closing bank
    step(1'b0, ACT, 1'b1, 2'd1, 12'h111, 2'b00, "R5");
    step(1'b0, ACT, 1'b1, 2'd2, 12'h222, 2'b00, "R5");
    step(1'b0, PRE, 1'b1, 2'd1, 12'h000, 2'b00, "R5");
    step(1'b0, WR, 1'b1, 2'd2, 12'h404, 2'b11, "R5");
    step(1'b0, PRE, 1'b1, 2'd2, 12'h000, 2'b00, "R5");
    step(1'b0, ACT, 1'b1, 2'd0, 12'h333, 2'b00, "R5");
    step(1'b0, ACT, 1'b1, 2'd3, 12'h444, 2'b00, "R5");
    step(1'b0, PRE, 1'b1, 2'd1, 12'h400, 2'b00, "R5");
    // R6: refresh with all idle
    step(1'b0, RF, 1'b1, 2'd0, 12'h000, 2'b00, "R6");
    // R7: self-refresh, ignored commands, exit
    step(1'b0, RF, 1'b0, 2'd0, 12'h000, 2'b00, "R7");
    step(1'b0, ACT, 1'b0, 2'd1, 12'h555, 2'b00, "R7");
    step(1'b0, RF, 1'b0, 2'd0, 12'h000, 2'b00, "R7");
    step(1'b0, ACT, 1'b1, 2'd1, 12'h666, 2'b00, "R7");
    step(1'b0, ACT, 1'b1, 2'd1, 12'h777, 2'b00, "R7");
    step(1'b0, PRE, 1'b1, 2'd0, 12'h400, 2'b00, "R5");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] rcw;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    rcw = ACT;
        2, 3:    rcw = RD;
        4:       rcw = WR;
        5:       rcw = PRE;
        6:       rcw = RF;
        default: rcw = 3'($urandom);
      endcase
      step(($urandom_range(0, 7) == 0), rcw, ($urandom_range(0, 5) != 0),
           2'($urandom), 12'($urandom), 2'($urandom), "R2");
    end

    // R9: reset in the middle of activity
    step(1'b0, ACT, 1'b1, 2'd2, 12'h9AB, 2'b00, "R3");
    rst_ni = 1'b0;
    for (int b = 0; b < 4; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_row[b] = '0; end
    m_sref = 1'b0; e_bank = '0; e_row = '0; e_col = '0;
    #1;
    compare_all(9'b0, "R9");
    @(negedge clk);
    rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule